// File: doc/BRIEF.md
# Flash Block Protection Controller

This block keeps the write-protection state of every erase block in a small flash-style memory. It watches a plain write bus with a strobe, an address and 16 data bits, and decodes the two-write protection commands that software sends to a block address. For each block it holds a lock bit and a lock-down bit. The program/erase engine asks it whether a given block may be changed, and the controller raises error bits in an 8-bit status register when a request is refused or a command sequence is malformed.

An active-low protect pin decides whether lock-down is enforced. While the pin is low, a locked-down block cannot be unlocked by any command. While it is high, such a block behaves like an ordinary locked block and can be unlocked and relocked. When the pin drops again, every block that was ever locked down returns to the locked state. In identifier mode the controller answers reads with a block's lock bits. It also tracks erase-suspend and program-suspend, because the suspend state decides whether protection commands are accepted.

The read port returns one result for each request, one cycle later, and applies no back-pressure. The requester must accept `rd_data` in the cycle that `rd_valid` is high. A command word is recognised only when its upper byte is zero. The block index is taken from address bits `[OFS_W +: BLK_W]`.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After reset every block has its lock bit set and its lock-down bit clear. The status register reads zero, the read mode is array mode and neither suspend state is active.
- R2: A write of 0x0060 to a block address starts a protection sequence. The next write completes it: 0x0001 locks, 0x00D0 unlocks and 0x002F locks down the block addressed by that second write, and the change is visible from the following cycle.
- R3: If the write after 0x0060 is any other value, status bits 5 and 4 are both set. They stay set until a clear command or reset, including across an erase resume.
- R4: `pe_ok` is high exactly when block `pe_blk` has its lock bit clear. A `pe_try` pulse on a block whose lock bit is set sets status bit 1.
- R5: While `wprot_n` is low, a block whose lock-down bit is set ignores lock, unlock and lock-down commands.
- R6: While `wprot_n` is high, a locked-down block can be unlocked and relocked by command, and it keeps its lock-down bit.
- R7: On a high-to-low change of `wprot_n`, every block with its lock-down bit set gets its lock bit set again, whatever commands were applied while the pin was high.
- R8: The lock-down bit is set only by the lock-down command, which also sets the lock bit, and is cleared only by reset.
- R9: After 0x0090 the block is in identifier mode. A read at block base + 0x2 returns the lock bit on bit 0 and the lock-down bit on bit 1, one cycle after `rd_en`, with `rd_valid`. 0x00FF returns to array mode, where every read returns zero.
- R10: 0x00B0 while `erase_busy` is high enters erase-suspend, shown on status bit 6. Protection commands are accepted and take effect at once while suspended. A 0x00D0 that is not the second write of a sequence resumes and clears bits 6 and 2.
- R11: 0x00B0 while only `prog_busy` is high enters program-suspend, shown on status bit 2. While program-suspend is active, 0x0060 is ignored, so the following write is not taken as a second cycle.
- R12: 0x0050 clears status bits 5, 4 and 1.
- R13: A write whose upper data byte is non-zero is not recognised as any command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Write address; block index in the upper BLK_W bits |
| wr_data | input | 16 | Write data / command word |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read result valid, one cycle after rd_en |
| rd_data | output | 16 | Read result |
| wprot_n | input | 1 | Low: lock-down enforced; high: lock-down suspended |
| erase_busy | input | 1 | Engine is erasing |
| prog_busy | input | 1 | Engine is programming |
| pe_try | input | 1 | Engine attempts a program/erase on pe_blk |
| pe_blk | input | BLK_W | Target block of the engine |
| pe_ok | output | 1 | Target block may be altered |
| sr | output | 8 | Status: bit6 erase-suspended, bits5:4 sequence error, bit2 program-suspended, bit1 protection error |

## Verification
The bench goes after the edges of the protect pin. It unlocks a locked-down block while the pin is high and then drops the pin; a design that cleared the lock-down bit on unlock, or that acted only on the pin level, would leave that block writable. It also sends a bad second cycle during erase-suspend and then resumes; a design that cleared errors on resume would lose bits 5:4. It checks program-suspend, where a design that still accepted 0x0060 would relock a block when the stray 0x0001 arrived, and a reset after lock-down, where a surviving lock-down bit would show up in the identifier read. Random sequences that mix commands, pin toggles and engine attempts are compared against a bench model after every step.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
  localparam int DATA_W = 16;

  localparam logic [DATA_W-1:0] CMD_SETUP   = 16'h0060;
  localparam logic [DATA_W-1:0] CMD_LOCK    = 16'h0001;
  localparam logic [DATA_W-1:0] CMD_UNLOCK  = 16'h00D0;
  localparam logic [DATA_W-1:0] CMD_LDOWN   = 16'h002F;
  localparam logic [DATA_W-1:0] CMD_CLR_SR  = 16'h0050;
  localparam logic [DATA_W-1:0] CMD_ID_MODE = 16'h0090;
  localparam logic [DATA_W-1:0] CMD_ARRAY   = 16'h00FF;
  localparam logic [DATA_W-1:0] CMD_SUSPEND = 16'h00B0;
  localparam logic [DATA_W-1:0] CMD_RESUME  = 16'h00D0;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_LOCK   = 2'd1,
    OP_UNLOCK = 2'd2,
    OP_LDOWN  = 2'd3
  } prot_op_e;
endpackage

// File: rtl/flash_lock_cmd.sv
module flash_lock_cmd
  import flash_lock_pkg::*;
#(
  parameter int BLK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              erase_busy,
  input  logic              prog_busy,
  output logic              op_valid,
  output prot_op_e          op_kind,
  output logic [BLK_W-1:0]  op_blk,
  output logic              seq_err,
  output logic              sr_clr,
  output logic              setup_pend,
  output logic              id_mode,
  output logic              susp_erase,
  output logic              susp_prog
);
  logic setup_q;
  logic id_q;
  logic se_q;
  logic sp_q;

  assign op_blk     = wr_blk;
  assign setup_pend = setup_q;
  assign id_mode    = id_q;
  assign susp_erase = se_q;
  assign susp_prog  = sp_q;

  // second-cycle decode, combinational on the completing write
  always_comb begin
    op_valid = 1'b0;
    op_kind  = OP_NONE;
    seq_err  = 1'b0;
    sr_clr   = 1'b0;
    if (wr_en && setup_q) begin
      unique case (wr_data)
        CMD_LOCK:   begin op_valid = 1'b1; op_kind = OP_LOCK;   end
        CMD_UNLOCK: begin op_valid = 1'b1; op_kind = OP_UNLOCK; end
        CMD_LDOWN:  begin op_valid = 1'b1; op_kind = OP_LDOWN;  end
        default:    seq_err = 1'b1;
      endcase
    end else if (wr_en && wr_data == CMD_CLR_SR) begin
      sr_clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= 1'b0;
      id_q    <= 1'b0;
      se_q    <= 1'b0;
      sp_q    <= 1'b0;
    end else if (wr_en) begin
      if (setup_q) begin
        setup_q <= 1'b0;
      end else begin
        unique case (wr_data)
          CMD_SETUP:   setup_q <= !sp_q;
          CMD_ID_MODE: id_q    <= 1'b1;
          CMD_ARRAY:   id_q    <= 1'b0;
          CMD_SUSPEND: begin
            if (!se_q && !sp_q) begin
              if (erase_busy)     se_q <= 1'b1;
              else if (prog_busy) sp_q <= 1'b1;
            end
          end
          CMD_RESUME: begin
            se_q <= 1'b0;
            sp_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_lock_bank.sv
module flash_lock_bank
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int BLK_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wprot_n,
  input  logic               op_valid,
  input  prot_op_e           op_kind,
  input  logic [BLK_W-1:0]   op_blk,
  output logic [NUM_BLK-1:0] lk,
  output logic [NUM_BLK-1:0] ld
);
  logic wp_q;
  logic wp_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_q <= 1'b0;
    else        wp_q <= wprot_n;
  end

  assign wp_fall = wp_q && !wprot_n;

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
    logic lk_r;
    logic ld_r;
    logic hit;
    logic frozen;

    assign hit    = op_valid && (op_blk == BLK_W'(i));
    assign frozen = ld_r && !wprot_n;
    assign lk[i]  = lk_r;
    assign ld[i]  = ld_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lk_r <= 1'b1;
        ld_r <= 1'b0;
      end else if (wp_fall && ld_r) begin
        lk_r <= 1'b1;
      end else if (hit && !frozen) begin
        unique case (op_kind)
          OP_LOCK:   lk_r <= 1'b1;
          OP_UNLOCK: lk_r <= 1'b0;
          OP_LDOWN: begin
            lk_r <= 1'b1;
            ld_r <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_lock_sr.sv
module flash_lock_sr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seq_err,
  input  logic       prot_err,
  input  logic       sr_clr,
  input  logic       susp_erase,
  input  logic       susp_prog,
  output logic [7:0] sr
);
  logic err_cmd;
  logic err_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cmd  <= 1'b0;
      err_lock <= 1'b0;
    end else begin
      if (sr_clr) begin
        err_cmd  <= 1'b0;
        err_lock <= 1'b0;
      end
      if (seq_err)  err_cmd  <= 1'b1;
      if (prot_err) err_lock <= 1'b1;
    end
  end

  assign sr = {1'b0, susp_erase, err_cmd, err_cmd, 1'b0, susp_prog, err_lock, 1'b0};
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int OFS_W   = 12,
  parameter int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  parameter int ADDR_W  = OFS_W + BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  input  logic              wprot_n,
  input  logic              erase_busy,
  input  logic              prog_busy,
  input  logic              pe_try,
  input  logic [BLK_W-1:0]  pe_blk,
  output logic              pe_ok,
  output logic [7:0]        sr
);
  localparam logic [OFS_W-1:0] STAT_OFS = OFS_W'(2);

  logic               op_valid;
  prot_op_e           op_kind;
  logic [BLK_W-1:0]   op_blk;
  logic               seq_err;
  logic               sr_clr;
  logic               setup_pend;
  logic               id_mode;
  logic               susp_erase;
  logic               susp_prog;
  logic [NUM_BLK-1:0] lk_vec;
  logic [NUM_BLK-1:0] ld_vec;
  logic               unused_wr_ofs;
  logic [BLK_W-1:0]   rd_blk;
  logic               rd_blk_ok;
  logic               pe_blk_ok;

  assign unused_wr_ofs = ^wr_addr[OFS_W-1:0];

  flash_lock_cmd #(.BLK_W(BLK_W)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_blk     (wr_addr[OFS_W +: BLK_W]),
    .wr_data    (wr_data),
    .erase_busy (erase_busy),
    .prog_busy  (prog_busy),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .op_blk     (op_blk),
    .seq_err    (seq_err),
    .sr_clr     (sr_clr),
    .setup_pend (setup_pend),
    .id_mode    (id_mode),
    .susp_erase (susp_erase),
    .susp_prog  (susp_prog)
  );

  flash_lock_bank #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wprot_n  (wprot_n),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .op_blk   (op_blk),
    .lk       (lk_vec),
    .ld       (ld_vec)
  );

  assign pe_blk_ok = int'(pe_blk) < NUM_BLK;
  assign pe_ok     = pe_blk_ok && !lk_vec[pe_blk];

  flash_lock_sr u_sr (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_err    (seq_err),
    .prot_err   (pe_try && !pe_ok),
    .sr_clr     (sr_clr),
    .susp_erase (susp_erase),
    .susp_prog  (susp_prog),
    .sr         (sr)
  );

  assign rd_blk    = rd_addr[OFS_W +: BLK_W];
  assign rd_blk_ok = int'(rd_blk) < NUM_BLK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (id_mode && rd_blk_ok && rd_addr[OFS_W-1:0] == STAT_OFS)
          rd_data <= {14'd0, ld_vec[rd_blk], lk_vec[rd_blk]};
        else
          rd_data <= '0;
      end
    end
  end
endmodule

// File: rtl/flash_lock_ctrl_chk.sv
module flash_lock_ctrl_chk #(
  parameter int NUM_BLK = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [15:0]        wr_data,
  input logic               rd_en,
  input logic               rd_valid,
  input logic               wprot_n,
  input logic               pe_try,
  input logic               pe_ok,
  input logic [7:0]         sr,
  input logic               setup_pend,
  input logic [NUM_BLK-1:0] lk,
  input logic [NUM_BLK-1:0] ld
);
  // R1
  reset_locks_all_chk: assert property (@(posedge clk)
    !rst_n |=> ((&lk) && (ld == '0) && (sr == 8'd0)));

  // R8
  lockdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ld) |=> ((ld & $past(ld)) == $past(ld)));

  // R7
  wp_low_relocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wprot_n && !$past(wprot_n)) |-> ((ld & ~lk) == '0));

  // R4
  protect_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_try && !pe_ok) |=> sr[1]);

  // R3
  seq_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_pend && wr_en && wr_data != 16'h0001 && wr_data != 16'h00D0 &&
     wr_data != 16'h002F) |=> (sr[5] && sr[4]));

  // R11
  prog_susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr[2] && wr_en && (wprot_n == $past(wprot_n))) |=> ($stable(lk) && $stable(ld)));

  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

bind flash_lock_ctrl flash_lock_ctrl_chk #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .wprot_n    (wprot_n),
  .pe_try     (pe_try),
  .pe_ok      (pe_ok),
  .sr         (sr),
  .setup_pend (setup_pend),
  .lk         (lk_vec),
  .ld         (ld_vec)
);

// File: tb/flash_lock_ctrl_test.sv
module flash_lock_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 8;
  localparam int OFS = 12;
  localparam int BW  = 3;
  localparam int AW  = OFS + BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_valid;
  logic [15:0]   rd_data;
  logic          wprot_n = 1'b0;
  logic          erase_busy = 1'b0;
  logic          prog_busy = 1'b0;
  logic          pe_try = 1'b0;
  logic [BW-1:0] pe_blk = '0;
  logic          pe_ok;
  logic [7:0]    sr;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_lock_ctrl #(.NUM_BLK(NB), .OFS_W(OFS)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wprot_n(wprot_n), .erase_busy(erase_busy), .prog_busy(prog_busy),
    .pe_try(pe_try), .pe_blk(pe_blk), .pe_ok(pe_ok), .sr(sr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  bit m_lk[NB];
  bit m_ld[NB];
  bit m_s1, m_s45, m_id, m_setup, m_se, m_sp, m_wp;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_sr();
    return {1'b0, m_se, m_s45, m_s45, 1'b0, m_sp, m_s1, 1'b0};
  endfunction

  function automatic logic [15:0] exp_stat(input int b);
    return m_id ? {14'd0, m_ld[b], m_lk[b]} : 16'd0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin m_lk[i] = 1'b1; m_ld[i] = 1'b0; end
    m_s1 = 0; m_s45 = 0; m_id = 0; m_setup = 0; m_se = 0; m_sp = 0;
  endtask

  task automatic model_write(input int b, input logic [15:0] d);
    if (m_setup) begin
      m_setup = 0;
      case (d)
        16'h0001: if (!(m_ld[b] && !m_wp)) m_lk[b] = 1;
        16'h00D0: if (!(m_ld[b] && !m_wp)) m_lk[b] = 0;
        16'h002F: if (!(m_ld[b] && !m_wp)) begin m_lk[b] = 1; m_ld[b] = 1; end
        default:  m_s45 = 1;
      endcase
    end else begin
      case (d)
        16'h0060: if (!m_sp) m_setup = 1;
        16'h0050: begin m_s1 = 0; m_s45 = 0; end
        16'h0090: m_id = 1;
        16'h00FF: m_id = 0;
        16'h00B0: if (!m_se && !m_sp) begin
                    if (erase_busy) m_se = 1;
                    else if (prog_busy) m_sp = 1;
                  end
        16'h00D0: begin m_se = 0; m_sp = 0; end
        default: ;
      endcase
    end
  endtask

  task automatic wr(input int b, input logic [15:0] d);
    wr_en = 1; wr_addr = {BW'(b), OFS'(0)}; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
    model_write(b, d);
  endtask

  task automatic rd_stat(input string tag, input int b);
    rd_en = 1; rd_addr = {BW'(b), OFS'(2)};
    @(posedge clk); #1;
    rd_en = 0;
    check(tag, {15'd0, rd_valid}, 16'd1);
    check(tag, rd_data, exp_stat(b));
  endtask

  task automatic chk_sr(input string tag);
    check(tag, {8'd0, sr}, {8'd0, exp_sr()});
  endtask

  task automatic pe(input string tag, input int b);
    pe_try = 1; pe_blk = BW'(b);
    #1;
    check(tag, {15'd0, pe_ok}, {15'd0, !m_lk[b]});
    @(posedge clk); #1;
    pe_try = 0;
    if (m_lk[b]) m_s1 = 1;
  endtask

  task automatic set_wp(input bit v);
    wprot_n = v;
    @(posedge clk); #1;
    if (m_wp && !v)
      for (int i = 0; i < NB; i++) if (m_ld[i]) m_lk[i] = 1;
    m_wp = v;
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(posedge clk); #1;
    rst_n = 1;
    model_reset();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd5150));
    m_wp = 0;
    model_reset();
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst_n = 1;

    // R1 reset state
    chk_sr("R1 sr");
    rd_stat("R1 array-mode read", 0);
    wr(0, 16'h0090);
    for (int b = 0; b < NB; b++) rd_stat("R1 locked after reset", b);

    // R2 / R4 unlock then engine access
    wr(2, 16'h0060); wr(2, 16'h00D0);
    rd_stat("R2 unlock", 2);
    pe("R4 ok on unlocked", 2);
    pe("R4 refused on locked", 3);
    chk_sr("R4 sr1 set");
    wr(0, 16'h0050);
    chk_sr("R12 clear");

    // R8 / R5 lock-down with pin low
    wr(2, 16'h0060); wr(2, 16'h002F);
    rd_stat("R8 lockdown sets both", 2);
    wr(2, 16'h0060); wr(2, 16'h00D0);
    rd_stat("R5 frozen unlock ignored", 2);
    pe("R5 still protected", 2);

    // R6 / R7 pin high override and snap back
    set_wp(1);
    wr(2, 16'h0060); wr(2, 16'h00D0);
    rd_stat("R6 unlock under pin high", 2);
    pe("R6 writable", 2);
    wr(2, 16'h0060); wr(2, 16'h0001);
    wr(2, 16'h0060); wr(2, 16'h00D0);
    rd_stat("R6 relock/unlock", 2);
    set_wp(0);
    rd_stat("R7 snap back", 2);

    // R3 bad second cycle
    wr(0, 16'h0050);
    wr(4, 16'h0060); wr(4, 16'h0040);
    chk_sr("R3 seq error");
    rd_stat("R3 no change", 4);
    wr(0, 16'h0050);

    // R10 erase suspend
    erase_busy = 1;
    wr(0, 16'h00B0);
    chk_sr("R10 erase suspended");
    wr(5, 16'h0060); wr(5, 16'h00D0);
    rd_stat("R10 unlock in suspend", 5);
    wr(5, 16'h0060); wr(5, 16'h0077);
    wr(0, 16'h00D0);
    chk_sr("R3 error kept after resume");
    wr(0, 16'h0050);
    erase_busy = 0;

    // R11 program suspend
    prog_busy = 1;
    wr(0, 16'h00B0);
    chk_sr("R11 program suspended");
    wr(5, 16'h0060); wr(5, 16'h0001);
    rd_stat("R11 setup rejected", 5);
    chk_sr("R11 no seq error");
    wr(0, 16'h00D0);
    chk_sr("R10 resume clears");
    prog_busy = 0;

    // R9 / R13 modes
    wr(0, 16'h00FF);
    rd_stat("R9 array read zero", 5);
    wr(0, 16'h0190);
    rd_stat("R13 upper byte not a command", 5);
    wr(0, 16'h0090);
    rd_addr = {BW'(2), OFS'(4)}; rd_en = 1;
    @(posedge clk); #1; rd_en = 0;
    check("R9 other offset zero", rd_data, 16'd0);

    // R1 reset clears lock-down
    do_reset();
    wr(0, 16'h0090);
    rd_stat("R1 lockdown cleared by reset", 2);

    // random phase
    for (int it = 0; it < 600; it++) begin
      int b;
      int sel;
      b   = int'($urandom_range(0, NB-1));
      sel = int'($urandom_range(0, 7));
      case (sel)
        0, 1, 2: begin
          logic [15:0] k;
          case ($urandom_range(0, 4))
            0: k = 16'h0001;
            1: k = 16'h00D0;
            2: k = 16'h002F;
            3: k = 16'h00D0;
            default: k = 16'h0042;
          endcase
          wr(b, 16'h0060); wr(b, k);
          rd_stat("R2 random sequence", b);
        end
        3: begin set_wp(!m_wp); rd_stat("R7 random pin", b); end
        4: pe("R4 random attempt", b);
        5: rd_stat("R9 random read", b);
        6: wr(0, 16'h0050);
        default: wr(0, ($urandom_range(0, 3) == 0) ? 16'h00FF : 16'h0090);
      endcase
      chk_sr("R12 random status");
    end

    finish_run();
  end
endmodule